// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt events into a sticky 16-bit status word, filters it through a 16-bit mask word and drives a single active-high interrupt request. Software reaches both words one byte at a time. The mask has separate write strobes for its low and high halves. Status bits are cleared through two acknowledge strobes, one per byte, with write-one-to-clear behaviour.

Four event sources feed the upper status byte: a periodic timer tick, an alarm match, a time-update error and a push-button. The button is an asynchronous level input. It is synchronized and edge-qualified, so only a press sets its bit. Software reads registers through a registered byte-wide read port that is addressed by a small select code.

Top module: `irqc_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, the mask reads 0x0FFF, the status reads 0x0000 and `irq_out` is 0.
- R2: `irq_out` is registered and equals the OR over all 16 bits of (status AND NOT mask), where status and mask are the values updated on the same clock edge. It therefore follows every mask write, acknowledge write and event on the edge that applies it.
- R3: A `wr_mask_lo` strobe loads `wr_data` into mask bits 7:0 and leaves bits 15:8 unchanged. A `wr_mask_hi` strobe loads bits 15:8 and leaves bits 7:0 unchanged.
- R4: A `wr_ack_lo` strobe clears each status bit 7:0 whose matching `wr_data` bit is 1. `wr_ack_hi` does the same for bits 15:8. Apart from this and reset, status bits stay set.
- R5: The `rd_sel` codes are 0 = mask low, 1 = mask high, 2 = status low, 3 = status high, 4 = acknowledge low, 5 = acknowledge high. Codes 4, 5, 6 and 7 read 0x00. `rd_data` is registered and shows the selected byte one edge after `rd_sel` is applied.
- R6: A one-cycle pulse sets a status bit: `evt_tick` sets bit 8, `evt_alarm` sets bit 9 and `evt_upd_err` sets bit 10.
- R7: Bit 11 is set only on a low-to-high transition of `btn_in`, after a two-flop synchronizer. A level that stays high does not set the bit again after it has been acknowledged.
- R8: When an event and an acknowledge hit the same status bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Write data for all write strobes |
| wr_mask_lo | input | 1 | Load mask bits 7:0 |
| wr_mask_hi | input | 1 | Load mask bits 15:8 |
| wr_ack_lo | input | 1 | Clear status bits 7:0 where wr_data is 1 |
| wr_ack_hi | input | 1 | Clear status bits 15:8 where wr_data is 1 |
| rd_sel | input | 3 | Read select code |
| rd_data | output | 8 | Registered read data |
| evt_tick | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_upd_err | input | 1 | Time-update error event pulse |
| btn_in | input | 1 | Asynchronous push-button level |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands on the same edge as an acknowledge of its own bit. The bench builds it by driving `evt_tick` together with `wr_ack_hi` set to 0x01 in one cycle, then reads status high back. The second hard case is a button held high across an acknowledge. The bench holds `btn_in` high, clears bit 11, waits several cycles and confirms that the bit stays clear until the button is released and pressed again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W   = 8;
  localparam int N_BYTES  = 2;
  localparam int STAT_W   = DATA_W * N_BYTES;
  localparam int SEL_W    = 3;

  localparam logic [STAT_W-1:0] MASK_RST = 16'h0FFF;

  localparam int TICK_BIT = 8;
  localparam int ALRM_BIT = 9;
  localparam int UERR_BIT = 10;
  localparam int BTN_BIT  = 11;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK_LO = 3'd0,
    SEL_MASK_HI = 3'd1,
    SEL_STAT_LO = 3'd2,
    SEL_STAT_HI = 3'd3,
    SEL_ACK_LO  = 3'd4,
    SEL_ACK_HI  = 3'd5
  } rd_sel_e;
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R7: a held level yields a single edge
  p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [N_BYTES-1:0]  wr_mask,
  input  logic [N_BYTES-1:0]  wr_ack,
  input  logic [STAT_W-1:0]   set_vec,
  output logic [STAT_W-1:0]   mask_q,
  output logic [STAT_W-1:0]   status_q,
  output logic                irq_q
);
  logic [STAT_W-1:0] mask_d;
  logic [STAT_W-1:0] status_d;

  genvar b;
  generate
    for (b = 0; b < N_BYTES; b++) begin : g_lane
      always_comb begin
        mask_d[b*DATA_W +: DATA_W] = wr_mask[b] ? wr_data
                                                : mask_q[b*DATA_W +: DATA_W];
        status_d[b*DATA_W +: DATA_W] =
            (status_q[b*DATA_W +: DATA_W] & ~(wr_ack[b] ? wr_data : '0))
          | set_vec[b*DATA_W +: DATA_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= MASK_RST;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      status_q <= status_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  // R1: reset values
  p_reset_vals_r1: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == MASK_RST && status_q == '0 && !irq_q));

  // R2: output agrees with stored words
  p_irq_match_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(status_q & ~mask_q));

  // R3: untouched mask byte holds
  p_mask_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_mask[1] |=> $stable(mask_q[STAT_W-1:DATA_W]));
  p_mask_lo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_mask[0] |=> $stable(mask_q[DATA_W-1:0]));

  genvar i;
  generate
    for (i = 0; i < STAT_W; i++) begin : g_bitchk
      // R4: a bit only drops when acknowledged
      p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_q[i]) && !$past(rst)) |->
          $past(wr_ack[i / DATA_W] & wr_data[i % DATA_W]));
      // R8: set wins over same-cycle clear
      p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> status_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [STAT_W-1:0] mask_q,
  input  logic [STAT_W-1:0] status_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    case (rd_sel)
      SEL_MASK_LO: rd_d = mask_q[DATA_W-1:0];
      SEL_MASK_HI: rd_d = mask_q[STAT_W-1:DATA_W];
      SEL_STAT_LO: rd_d = status_q[DATA_W-1:0];
      SEL_STAT_HI: rd_d = status_q[STAT_W-1:DATA_W];
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  // R5: acknowledge and unused codes read zero
  p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_sel >= SEL_ACK_LO) |=> (rd_data == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mask_lo,
  input  logic              wr_mask_hi,
  input  logic              wr_ack_lo,
  input  logic              wr_ack_hi,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_tick,
  input  logic              evt_alarm,
  input  logic              evt_upd_err,
  input  logic              btn_in,
  output logic              irq_out
);
  logic              btn_rise;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] status_q;

  irqc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk      (clk),
    .rst      (rst),
    .async_in (btn_in),
    .rise     (btn_rise)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[TICK_BIT] = evt_tick;
    set_vec[ALRM_BIT] = evt_alarm;
    set_vec[UERR_BIT] = evt_upd_err;
    set_vec[BTN_BIT]  = btn_rise;
  end

  irqc_status_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .wr_mask  ({wr_mask_hi, wr_mask_lo}),
    .wr_ack   ({wr_ack_hi, wr_ack_lo}),
    .set_vec  (set_vec),
    .mask_q   (mask_q),
    .status_q (status_q),
    .irq_q    (irq_out)
  );

  irqc_read_mux u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .mask_q   (mask_q),
    .status_q (status_q),
    .rd_data  (rd_data)
  );

  // R6: a tick pulse shows up in status on the next edge
  p_tick_sets_r6: assert property (@(posedge clk) disable iff (rst)
    evt_tick |=> status_q[TICK_BIT]);
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0;
  logic       wr_mask_lo = 0, wr_mask_hi = 0, wr_ack_lo = 0, wr_ack_hi = 0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       evt_tick = 0, evt_alarm = 0, evt_upd_err = 0, btn_in = 0;
  logic       irq_out;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst(rst), .wr_data(wr_data),
    .wr_mask_lo(wr_mask_lo), .wr_mask_hi(wr_mask_hi),
    .wr_ack_lo(wr_ack_lo), .wr_ack_hi(wr_ack_hi),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_tick(evt_tick), .evt_alarm(evt_alarm), .evt_upd_err(evt_upd_err),
    .btn_in(btn_in), .irq_out(irq_out)
  );

  // vector: op[22:20] data[19:12] rsel[11:9] exp_rd[8:1] exp_irq[0]
  // op: 0 none, 1 mask lo, 2 mask hi, 3 ack lo, 4 ack hi, 5 events
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 8'h00, 3'd0, 8'hFF, 1'b0},  // R1 mask lo
    {3'd0, 8'h00, 3'd1, 8'h0F, 1'b0},  // R1 mask hi
    {3'd5, 8'h01, 3'd3, 8'h01, 1'b0},  // R6 tick, masked
    {3'd2, 8'h0E, 3'd1, 8'h0E, 1'b1},  // R3/R2 unmask bit 8
    {3'd0, 8'h00, 3'd0, 8'hFF, 1'b1},  // R3 low kept
    {3'd1, 8'h00, 3'd0, 8'h00, 1'b1},  // R3 low loaded
    {3'd0, 8'h00, 3'd1, 8'h0E, 1'b1},  // R3 high kept
    {3'd5, 8'h06, 3'd3, 8'h07, 1'b1},  // R6 alarm+error
    {3'd4, 8'h01, 3'd3, 8'h06, 1'b0},  // R4 ack bit 8
    {3'd0, 8'h00, 3'd5, 8'h00, 1'b0},  // R5 ack hi reads 0
    {3'd0, 8'h00, 3'd4, 8'h00, 1'b0},  // R5 ack lo reads 0
    {3'd0, 8'h00, 3'd2, 8'h00, 1'b0},  // R5 status lo
    {3'd2, 8'h00, 3'd1, 8'h00, 1'b1},  // R2 unmask all
    {3'd4, 8'h06, 3'd3, 8'h00, 1'b0},  // R4 ack both
    {3'd0, 8'h00, 3'd6, 8'h00, 1'b0}   // R5 unused code
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    wr_data     = d;
    wr_mask_lo  = (op == 3'd1);
    wr_mask_hi  = (op == 3'd2);
    wr_ack_lo   = (op == 3'd3);
    wr_ack_hi   = (op == 3'd4);
    evt_tick    = (op == 3'd5) & d[0];
    evt_alarm   = (op == 3'd5) & d[1];
    evt_upd_err = (op == 3'd5) & d[2];
    @(negedge clk);
    {wr_mask_lo, wr_mask_hi, wr_ack_lo, wr_ack_hi} = '0;
    {evt_tick, evt_alarm, evt_upd_err} = '0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, irq_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(3'd2, v); check("R1 status lo", v, 8'h00);
    rd(3'd3, v); check("R1 status hi", v, 8'h00);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][22:20], VEC[k][19:12]);
      rd(VEC[k][11:9], v);
      check($sformatf("R2/R3/R4/R5/R6 vec %0d rd", k), v, VEC[k][8:1]);
      check($sformatf("R2 vec %0d irq", k), {7'd0, irq_out}, {7'd0, VEC[k][0]});
    end

    // R7: button press, hold, ack, no re-set
    btn_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd3, v); check("R7 press sets bit 11", v, 8'h08);
    check("R2 irq from button", {7'd0, irq_out}, 8'h01);
    apply(3'd4, 8'h08);
    repeat (8) @(negedge clk);
    rd(3'd3, v); check("R7 held level no re-set", v, 8'h00);
    btn_in = 1'b0;
    repeat (5) @(negedge clk);
    btn_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd3, v); check("R7 second press", v, 8'h08);
    apply(3'd4, 8'h08);

    // R8: tick and ack of bit 8 on the same edge
    @(negedge clk);
    wr_data = 8'h01; wr_ack_hi = 1'b1; evt_tick = 1'b1;
    @(negedge clk);
    wr_ack_hi = 1'b0; evt_tick = 1'b0;
    rd(3'd3, v); check("R8 set beats clear", v, 8'h01);

    // R2: masking drops the output
    apply(3'd2, 8'hFF);
    check("R2 irq masked", {7'd0, irq_out}, 8'h00);

    // R4: ack lo does not touch high byte
    apply(3'd3, 8'hFF);
    rd(3'd3, v); check("R4 ack lo leaves hi", v, 8'h01);

    // R1: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(3'd1, v); check("R1 mask hi after reset", v, 8'h0F);
    rd(3'd3, v); check("R1 status hi after reset", v, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule